// File: doc/BRIEF.md
# Circular-Buffer Pointer Address Generator

This block produces data-memory addresses from a small file of pointer registers. It is built for programs that keep a delay line or circular shift register in ordinary memory. The stored samples never move. Only the pointer moves, and two boundary registers mark the lowest and highest word of the circular region. On each accepted access the block emits the selected pointer's current value as the address. It then updates that pointer according to a three-bit access-mode code.

Only the wrapping increment modes look at the boundaries. These are the plain post-increment mode and the two paired zero/increment modes. When the pointer equals the high boundary, the pointer is reloaded with the low boundary instead of being incremented. Every other update mode does plain modular arithmetic and ignores the region. A pointer that lies outside the region therefore steps past it freely.

The access side is a valid/ready stream. `acc_valid` presents a request, `addr_valid` mirrors it toward memory, and memory accepts with `mem_ready`, which is returned as `acc_ready`. An access is consumed, and the pointer is updated, only in a cycle where both `acc_valid` and `mem_ready` are high. While `mem_ready` is low the requester holds its request, the address stays on the bus, and no pointer changes. Register writes are plain enables and are never stalled.

Top module: `modptr_agen`

## Requirements
- R1: While `acc_valid` is high, `addr` equals the selected pointer's value before this access's update, `addr_valid` equals `acc_valid`, and `acc_ready` equals `mem_ready`. The update is visible from the next cycle.
- R2: Mode code 1 (wrapping increment): when the selected pointer equals the high boundary, the pointer becomes the low boundary.
- R3: Mode code 1 with the pointer not equal to the high boundary adds one modulo 2^16. A pointer outside the region never wraps, and 0xFFFF becomes 0x0000.
- R4: Mode code 2 (decrement by one) and mode code 5 (increment by two) ignore the boundaries, even when the pointer sits on the high boundary.
- R5: Paired modes take two accepted beats. In code 3 the first beat applies the wrapping increment and the second leaves the pointer unchanged. Code 4 is the reverse order. The beat phase restarts after any non-paired beat.
- R6: Mode code 0 and the reserved codes 6 and 7 leave the pointer unchanged.
- R7: A pointer write (`ptr_we`) takes priority over an automatic update of the same pointer in the same cycle. The other pointers update normally.
- R8: After reset, all pointers and both boundaries read zero.
- R9: While `mem_ready` is low, no pointer changes, whatever `acc_valid` and the mode are.
- R10: With a low boundary of 1 and a high boundary of 7, repeating eight wrapping accesses per sequence moves the first address forward by one each sequence (5, 6, 7, 1, 2). Within one sequence, after writing the newest sample at the start address, the block reads each older sample in order from oldest to newest. The sequence ends on the slot just written.
- R11: A boundary write in the same cycle as an access takes effect from the next cycle. The access uses the old boundary values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request present |
| acc_ready | output | 1 | Access accepted this cycle |
| acc_sel | input | 2 | Pointer used by the access |
| acc_mode | input | 3 | Update mode code (see R2 to R6) |
| addr_valid | output | 1 | Address on `addr` is valid |
| mem_ready | input | 1 | Memory accepts the address |
| addr | output | 16 | Memory address (pre-update pointer) |
| ptr_we | input | 1 | Write `wr_data` into pointer `ptr_wsel` |
| ptr_wsel | input | 2 | Pointer write target |
| lo_we | input | 1 | Write `wr_data` into the low boundary |
| hi_we | input | 1 | Write `wr_data` into the high boundary |
| wr_data | input | 16 | Write data for pointers and boundaries |

## Verification
The hardest situation to reach is the paired-mode wrap. A paired beat has to arrive exactly while the pointer sits on the high boundary, and the phase bit decides whether the wrap happens on that beat or on the following one. The bench first loads the pointer straight onto the high boundary with a register write. It then issues both orders of the pair, probing the pointer with a hold-mode access after each pair. The same-cycle collisions of a write with an update, and of a boundary write with a wrap, are reached by driving the write enable and the access in one cycle.

// File: rtl/modptr_pkg.sv
package modptr_pkg;

  typedef enum logic [2:0] {
    MD_HOLD = 3'd0,
    MD_INC  = 3'd1,
    MD_DEC  = 3'd2,
    MD_PZ   = 3'd3,
    MD_ZP   = 3'd4,
    MD_INC2 = 3'd5
  } mode_e;

  function automatic logic is_paired(input logic [2:0] m);
    return (m == MD_PZ) || (m == MD_ZP);
  endfunction

endpackage

// File: rtl/modptr_step.sv
module modptr_step #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  input  logic [2:0]    mode,
  input  logic          phase,
  output logic [AW-1:0] nxt
);
  import modptr_pkg::*;

  logic [AW-1:0] wrap_inc;

  // circular step: reload low bound when sitting on the high bound
  assign wrap_inc = (cur == hi) ? lo : cur + AW'(1);

  always_comb begin
    nxt = cur;
    case (mode)
      MD_INC:  nxt = wrap_inc;
      MD_DEC:  nxt = cur - AW'(1);
      MD_PZ:   nxt = phase ? cur : wrap_inc;
      MD_ZP:   nxt = phase ? wrap_inc : cur;
      MD_INC2: nxt = cur + AW'(2);
      default: nxt = cur;
    endcase
  end

endmodule

// File: rtl/modptr_bounds.sv
module modptr_bounds #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lo_we,
  input  logic          hi_we,
  input  logic [AW-1:0] wr_data,
  output logic [AW-1:0] lo_q,
  output logic [AW-1:0] hi_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (lo_we) lo_q <= wr_data;
      if (hi_we) hi_q <= wr_data;
    end
  end

endmodule

// File: rtl/modptr_regfile.sv
module modptr_regfile #(
  parameter int AW   = 16,
  parameter int NPTR = 4,
  localparam int SELW = (NPTR > 1) ? $clog2(NPTR) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     upd_en,
  input  logic [SELW-1:0]          upd_sel,
  input  logic [AW-1:0]            upd_val,
  input  logic                     we,
  input  logic [SELW-1:0]          wsel,
  input  logic [AW-1:0]            wdata,
  output logic [NPTR-1:0][AW-1:0]  ptr_q
);

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ptr_q[g] <= '0;
      end else if (we && (wsel == SELW'(g))) begin
        ptr_q[g] <= wdata;          // explicit write wins
      end else if (upd_en && (upd_sel == SELW'(g))) begin
        ptr_q[g] <= upd_val;
      end
    end
  end

endmodule

// File: rtl/modptr_agen.sv
module modptr_agen #(
  parameter int AW   = 16,
  parameter int NPTR = 4,
  localparam int SELW = (NPTR > 1) ? $clog2(NPTR) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_valid,
  output logic            acc_ready,
  input  logic [SELW-1:0] acc_sel,
  input  logic [2:0]      acc_mode,
  output logic            addr_valid,
  input  logic            mem_ready,
  output logic [AW-1:0]   addr,
  input  logic            ptr_we,
  input  logic [SELW-1:0] ptr_wsel,
  input  logic            lo_we,
  input  logic            hi_we,
  input  logic [AW-1:0]   wr_data
);
  import modptr_pkg::*;

  logic [NPTR-1:0][AW-1:0] ptr_q;
  logic [AW-1:0]           bnd_lo_q;
  logic [AW-1:0]           bnd_hi_q;
  logic [AW-1:0]           cur;
  logic [AW-1:0]           nxt;
  logic                    fire;
  logic                    phase_q;

  assign fire       = acc_valid && mem_ready;
  assign acc_ready  = mem_ready;
  assign addr_valid = acc_valid;
  assign cur        = ptr_q[acc_sel];
  assign addr       = cur;

  // paired-mode beat tracker
  always_ff @(posedge clk) begin
    if (!rst_n)     phase_q <= 1'b0;
    else if (fire)  phase_q <= is_paired(acc_mode) ? ~phase_q : 1'b0;
  end

  modptr_bounds #(.AW(AW)) u_bounds (
    .clk     (clk),
    .rst_n   (rst_n),
    .lo_we   (lo_we),
    .hi_we   (hi_we),
    .wr_data (wr_data),
    .lo_q    (bnd_lo_q),
    .hi_q    (bnd_hi_q)
  );

  modptr_step #(.AW(AW)) u_step (
    .cur   (cur),
    .lo    (bnd_lo_q),
    .hi    (bnd_hi_q),
    .mode  (acc_mode),
    .phase (phase_q),
    .nxt   (nxt)
  );

  modptr_regfile #(.AW(AW), .NPTR(NPTR)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_en  (fire),
    .upd_sel (acc_sel),
    .upd_val (nxt),
    .we      (ptr_we),
    .wsel    (ptr_wsel),
    .wdata   (wr_data),
    .ptr_q   (ptr_q)
  );

endmodule

// File: rtl/modptr_agen_chk.sv
module modptr_agen_chk #(
  parameter int AW   = 16,
  parameter int NPTR = 4,
  localparam int SELW = (NPTR > 1) ? $clog2(NPTR) : 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    acc_valid,
  input logic                    mem_ready,
  input logic [SELW-1:0]         acc_sel,
  input logic [2:0]              acc_mode,
  input logic                    ptr_we,
  input logic [SELW-1:0]         ptr_wsel,
  input logic [AW-1:0]           wr_data,
  input logic [NPTR-1:0][AW-1:0] ptr_q,
  input logic [AW-1:0]           bnd_lo_q,
  input logic [AW-1:0]           bnd_hi_q
);

  logic no_clash;
  assign no_clash = !(ptr_we && (ptr_wsel == acc_sel));

  a_r2_wrap_to_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && mem_ready && acc_mode == 3'd1 && ptr_q[acc_sel] == bnd_hi_q && no_clash)
    |=> ptr_q[$past(acc_sel)] == $past(bnd_lo_q));

  a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && mem_ready && acc_mode == 3'd1 && ptr_q[acc_sel] != bnd_hi_q && no_clash)
    |=> ptr_q[$past(acc_sel)] == AW'($past(ptr_q[acc_sel]) + AW'(1)));

  a_r4_dec_ignores_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && mem_ready && acc_mode == 3'd2 && no_clash)
    |=> ptr_q[$past(acc_sel)] == AW'($past(ptr_q[acc_sel]) - AW'(1)));

  a_r6_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && mem_ready && (acc_mode == 3'd0 || acc_mode >= 3'd6) && !ptr_we)
    |=> $stable(ptr_q));

  a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_we |=> ptr_q[$past(ptr_wsel)] == $past(wr_data));

  a_r9_stall_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ready && !ptr_we) |=> $stable(ptr_q));

endmodule

bind modptr_agen modptr_agen_chk #(.AW(AW), .NPTR(NPTR)) u_chk (.*);

// File: tb/modptr_agen_bench.sv
`timescale 1ns/1ps
module modptr_agen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_ready;
  logic [1:0]  acc_sel = '0;
  logic [2:0]  acc_mode = '0;
  logic        addr_valid;
  logic        mem_ready = 1'b1;
  logic [15:0] addr;
  logic        ptr_we = 1'b0;
  logic [1:0]  ptr_wsel = '0;
  logic        lo_we = 1'b0;
  logic        hi_we = 1'b0;
  logic [15:0] wr_data = '0;

  always #2 clk = ~clk;   // 250 MHz

  modptr_agen u_modptr_agen (.*);

  int          n_cmp = 0;
  int          n_bad = 0;
  logic [15:0] m_ptr [4];
  logic [15:0] m_lo, m_hi;
  bit          m_ph;
  logic [15:0] last_addr;

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] m_wrap(input logic [15:0] p);
    return (p == m_hi) ? m_lo : p + 16'd1;
  endfunction

  // one cycle of stimulus, checked against the reference model
  task automatic beat(input bit v, input bit rdy, input int sel, input int mode,
                      input bit pwe, input int psel, input bit lwe, input bit hwe,
                      input logic [15:0] wd, input string tag);
    logic [15:0] p, n;
    @(negedge clk);
    acc_valid = v; mem_ready = rdy; acc_sel = 2'(sel); acc_mode = 3'(mode);
    ptr_we = pwe; ptr_wsel = 2'(psel); lo_we = lwe; hi_we = hwe; wr_data = wd;
    #1;
    if (v) begin
      last_addr = addr;
      chk(addr, m_ptr[sel], {tag, " R1 addr"});
      chk({15'd0, addr_valid}, 16'd1, {tag, " R1 addr_valid"});
      chk({15'd0, acc_ready}, {15'd0, rdy}, {tag, " R1 acc_ready"});
    end
    @(posedge clk);
    #1;
    acc_valid = 1'b0; mem_ready = 1'b1; ptr_we = 1'b0; lo_we = 1'b0; hi_we = 1'b0;
    if (v && rdy) begin
      p = m_ptr[sel];
      case (mode)
        1: n = m_wrap(p);
        2: n = p - 16'd1;
        3: n = m_ph ? p : m_wrap(p);
        4: n = m_ph ? m_wrap(p) : p;
        5: n = p + 16'd2;
        default: n = p;
      endcase
      m_ptr[sel] = n;
      m_ph = (mode == 3 || mode == 4) ? ~m_ph : 1'b0;
    end
    if (pwe) m_ptr[psel] = wd;
    if (lwe) m_lo = wd;
    if (hwe) m_hi = wd;
  endtask

  task automatic acc(input int sel, input int mode, input string tag);
    beat(1, 1, sel, mode, 0, 0, 0, 0, 16'h0, tag);
  endtask
  task automatic wptr(input int sel, input logic [15:0] v);
    beat(0, 1, 0, 0, 1, sel, 0, 0, v, "wptr");
  endtask
  task automatic wbnd(input logic [15:0] lo, input logic [15:0] hi);
    beat(0, 1, 0, 0, 0, 0, 1, 0, lo, "wlo");
    beat(0, 1, 0, 0, 0, 0, 0, 1, hi, "whi");
  endtask
  task automatic peek(input int sel, input logic [15:0] exp, input string tag);
    acc(sel, 0, tag);
    chk(last_addr, exp, tag);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 4; i++) peek(i, 16'h0000, "R8 reset pointer");
    // boundaries are zero: a wrapping increment at 0 reloads 0
    acc(0, 1, "R8 bounds");
    peek(0, 16'h0000, "R8 reset bounds zero");
  endtask

  task automatic t_wrap;
    wbnd(16'd1, 16'd7);
    wptr(0, 16'd6);
    acc(0, 1, "R3 inside region");
    peek(0, 16'd7, "R3 inside region +1");
    acc(0, 1, "R2 at high bound");
    peek(0, 16'd1, "R2 wrap to low bound");
  endtask

  task automatic t_outside;
    wptr(1, 16'd20);
    acc(1, 1, "R3 outside");
    peek(1, 16'd21, "R3 outside region no wrap");
    wptr(1, 16'hFFFF);
    acc(1, 1, "R3 top");
    peek(1, 16'h0000, "R3 modulo 2^16");
  endtask

  task automatic t_nowrap;
    wptr(2, 16'd7);
    acc(2, 2, "R4 dec");
    peek(2, 16'd6, "R4 decrement ignores bounds");
    wptr(2, 16'd7);
    acc(2, 5, "R4 inc2");
    peek(2, 16'd9, "R4 step-two ignores bounds");
  endtask

  task automatic t_paired;
    wptr(0, 16'd7);
    acc(0, 3, "R5 pz beat1");
    chk(last_addr, 16'd7, "R5 pz first address");
    acc(0, 3, "R5 pz beat2");
    chk(last_addr, 16'd1, "R5 pz second address");
    peek(0, 16'd1, "R5 pz pair result");
    wptr(0, 16'd7);
    acc(0, 4, "R5 zp beat1");
    acc(0, 4, "R5 zp beat2");
    chk(last_addr, 16'd7, "R5 zp second address");
    peek(0, 16'd1, "R5 zp pair result");
  endtask

  task automatic t_hold;
    wptr(3, 16'h0042);
    acc(3, 0, "R6 mode0");
    acc(3, 6, "R6 mode6");
    acc(3, 7, "R6 mode7");
    peek(3, 16'h0042, "R6 hold and reserved codes");
  endtask

  task automatic t_write;
    wptr(3, 16'd3);
    beat(1, 1, 3, 1, 1, 3, 0, 0, 16'h1234, "R7 clash");
    peek(3, 16'h1234, "R7 write beats update");
    wptr(0, 16'd2);
    beat(1, 1, 0, 1, 1, 1, 0, 0, 16'h0055, "R7 other");
    peek(0, 16'd3, "R7 other pointer updates");
    peek(1, 16'h0055, "R7 written pointer");
  endtask

  task automatic t_stall;
    wptr(2, 16'd7);
    beat(1, 0, 2, 1, 0, 0, 0, 0, 16'h0, "R9 stall");
    chk({15'd0, acc_ready}, 16'd1, "R9 ready released");
    beat(1, 0, 2, 5, 0, 0, 0, 0, 16'h0, "R9 stall2");
    peek(2, 16'd7, "R9 no update while stalled");
  endtask

  task automatic t_bndclash;
    wptr(0, 16'd7);
    beat(1, 1, 0, 1, 0, 0, 0, 1, 16'd9, "R11 clash");
    peek(0, 16'd1, "R11 wrap uses old high bound");
    wptr(0, 16'd7);
    acc(0, 1, "R11 new bound");
    peek(0, 16'd8, "R11 new high bound in force");
    wbnd(16'd1, 16'd7);
  endtask

  task automatic t_delay;
    logic [15:0] starts [5];
    starts[0] = 16'd5; starts[1] = 16'd6; starts[2] = 16'd7;
    starts[3] = 16'd1; starts[4] = 16'd2;
    wptr(0, 16'd5);
    for (int s = 0; s < 5; s++) begin
      for (int k = 0; k < 8; k++) begin
        acc(0, 1, "R10 delay line");
        if (k == 0) chk(last_addr, starts[s], "R10 sequence start");
        if (k == 7) chk(last_addr, starts[s], "R10 ends on newest");
      end
    end
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog expired (all requirements)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) m_ptr[i] = 16'h0;
    m_lo = '0; m_hi = '0; m_ph = 1'b0; last_addr = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_wrap();
    t_outside();
    t_nowrap();
    t_paired();
    t_hold();
    t_write();
    t_stall();
    t_bndclash();
    t_delay();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule